// File: doc/BRIEF.md
# Hashed-Bank Lane Scheduler for Vector Memory Operations

This block takes one vector memory operation at a time: a lane address for each of the parallel lanes and a mask that says which lanes take part. It computes a bank number for every lane by folding two groups of address bits together. It then grants the lanes to a banked data cache over one or more cycles, so that in any cycle no two granted lanes use the same bank unless they name the very same address.

While the operation is in progress, a busy output holds every participating thread. An external miss indication freezes progress for the whole operation. A done pulse marks the cycle in which the last lane is granted, and the scheduler takes the next operation in the cycle after that. The cache arrays, address translation and miss handling sit outside this block.

Top module: `lsched_top`

## Requirements
- R1: For every lane i, `lane_bank[4*i+3:4*i]` equals address bits 15:12 XOR address bits 27:24 of that lane's stored address. There are 16 banks. Address bits 11:0 play no part in the bank choice.
- R2: Two lanes whose banks differ are never forced into separate cycles by each other. Two lanes granted in the same cycle never share a bank unless their addresses are equal.
- R3: Lanes with identical addresses are granted together in one cycle.
- R4: When lanes conflict, they are served in ascending lane order. In every cycle without a miss, the lowest-numbered lane still waiting is granted. Each lane is scanned in ascending order and is granted unless an already chosen lower lane holds its bank with a different address.
- R5: A lane whose `op_mask` bit is 0 is never granted. An operation with an all-zero mask raises `done` in the first cycle after it is accepted, with no grant.
- R6: `busy` is high from the cycle after acceptance through the `done` cycle. `op_valid` and the operation inputs are ignored while `busy` is high.
- R7: In a cycle with `cache_miss` high, `grant` is all zero, no waiting lane is retired, and `done` stays low unless no lane was waiting.
- R8: `done` is high for exactly one cycle, the cycle of the last grant. In the following cycle `busy` is low and an operation with `op_valid` high is accepted. Every active lane is granted exactly once per operation.
- R9: While `rst` is high and after it, until an operation is accepted, `busy`, `grant` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present; taken when `busy` is low |
| op_mask | input | NLANES | Active-lane mask, bit i for lane i |
| op_addr | input | NLANES*32 | Lane addresses, lane i at bits 32*i+31:32*i |
| cache_miss | input | 1 | Miss on an active lane; stalls the whole operation |
| busy | output | 1 | Stall for all participating threads |
| grant | output | NLANES | Lanes sent to the cache this cycle |
| lane_bank | output | NLANES*4 | Hashed bank index of each stored lane address |
| done | output | 1 | Pulse with the final grant of an operation |

## Verification
The bench builds the block with four lanes, 32-bit addresses and a 4-bit bank index. At this size every mask pattern is reachable, and so are four-deep serial conflict chains, mixed shared-address and conflicting groups, and aliasing between the two hashed bit fields. Random addresses are drawn only in the hashed fields and the low word bits, so that conflicts and identical addresses occur often. Misses are injected at random rates in the middle of operations, and noise is driven on the input pins while the block is busy.

// File: rtl/lsched_pkg.sv
package lsched_pkg;
    localparam int ADDR_W  = 32;
    localparam int BANK_W  = 4;
    localparam int HASH_LO = 12;
    localparam int HASH_HI = 24;
    localparam int LANES   = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} sched_state_e;

    // Fold a mid field and a high field of the address into a bank number
    function automatic bank_t bank_hash(addr_t a);
        return a[HASH_LO +: BANK_W] ^ a[HASH_HI +: BANK_W];
    endfunction
endpackage

// File: rtl/lsched_hash.sv
module lsched_hash
    import lsched_pkg::*;
#(
    parameter int NL = LANES
) (
    input  addr_t addr [NL],
    output bank_t bank [NL]
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign bank[i] = bank_hash(addr[i]);
    end
endmodule

// File: rtl/lsched_pick.sv
module lsched_pick
    import lsched_pkg::*;
#(
    parameter int NL = LANES
) (
    input  logic [NL-1:0] pend,
    input  logic          hold,
    input  addr_t         addr [NL],
    input  bank_t         bank [NL],
    output logic [NL-1:0] grant
);
    logic [NL-1:0] sel;

    // Ascending scan: a lane joins unless a lower chosen lane owns its bank
    // with a different address.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NL; i++) begin
            logic ok;
            ok = pend[i];
            for (int j = 0; j < NL; j++) begin
                if (j < i && sel[j] && bank[j] == bank[i] && addr[j] != addr[i])
                    ok = 1'b0;
            end
            sel[i] = ok;
        end
        grant = hold ? '0 : sel;
    end
endmodule

// File: rtl/lsched_top.sv
module lsched_top
    import lsched_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic [NLANES-1:0]        op_mask,
    input  logic [NLANES*ADDR_W-1:0] op_addr,
    input  logic                     cache_miss,
    output logic                     busy,
    output logic [NLANES-1:0]        grant,
    output logic [NLANES*BANK_W-1:0] lane_bank,
    output logic                     done
);
    sched_state_e  state_q;
    logic [NLANES-1:0] pend_q;
    logic [NLANES-1:0] remaining;
    addr_t addr_in [NLANES];
    addr_t addr_q  [NLANES];
    bank_t bank_w  [NLANES];
    logic  accept;
    logic  hold;

    always_comb begin
        for (int i = 0; i < NLANES; i++)
            addr_in[i] = op_addr[i*ADDR_W +: ADDR_W];
    end

    lsched_hash #(.NL(NLANES)) hash_i (
        .addr (addr_q),
        .bank (bank_w)
    );

    for (genvar i = 0; i < NLANES; i++) begin : g_bank_out
        assign lane_bank[i*BANK_W +: BANK_W] = bank_w[i];
    end

    assign hold = cache_miss || (state_q != ST_RUN);

    lsched_pick #(.NL(NLANES)) pick_i (
        .pend  (pend_q),
        .hold  (hold),
        .addr  (addr_q),
        .bank  (bank_w),
        .grant (grant)
    );

    assign accept    = (state_q == ST_IDLE) && op_valid;
    assign remaining = pend_q & ~grant;
    assign done      = (state_q == ST_RUN) && (remaining == '0);
    assign busy      = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            for (int i = 0; i < NLANES; i++) addr_q[i] <= '0;
        end else if (accept) begin
            state_q <= ST_RUN;
            pend_q  <= op_mask;
            for (int i = 0; i < NLANES; i++) addr_q[i] <= addr_in[i];
        end else if (state_q == ST_RUN) begin
            pend_q <= remaining;
            if (done) state_q <= ST_IDLE;
        end
    end

    // ---------------- assertions ----------------
    assert_miss_nogrant_R7: assert property (@(posedge clk) disable iff (rst)
        cache_miss |-> (grant == '0));

    assert_only_pending_R5: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~pend_q) == '0));

    assert_lowest_first_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !cache_miss && pend_q != '0) |-> ((grant & (pend_q & (~pend_q + 1'b1))) != '0));

    assert_done_frees_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(op_valid));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (grant == '0 && !done));

    for (genvar i = 0; i < NLANES; i++) begin : g_pair_i
        for (genvar j = i + 1; j < NLANES; j++) begin : g_pair_j
            assert_bank_excl_R2: assert property (@(posedge clk) disable iff (rst)
                (grant[i] && grant[j]) |-> (bank_w[i] != bank_w[j] || addr_q[i] == addr_q[j]));
        end
    end
endmodule

// File: tb/lsched_top_tb.sv
module lsched_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            op_valid;
    logic [NL-1:0]   op_mask;
    logic [NL*AW-1:0] op_addr;
    logic            cache_miss;
    logic            busy;
    logic [NL-1:0]   grant;
    logic [NL*4-1:0] lane_bank;
    logic            done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsched_top #(.NLANES(NL)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_mask(op_mask),
        .op_addr(op_addr), .cache_miss(cache_miss), .busy(busy),
        .grant(grant), .lane_bank(lane_bank), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_bank(input logic [31:0] a);
        return a[15:12] ^ a[27:24];
    endfunction

    // Expected grant set per the ascending-order rule
    function automatic logic [NL-1:0] ref_pick(input logic [NL-1:0] p, input logic [31:0] a [NL]);
        logic [NL-1:0] g = '0;
        for (int i = 0; i < NL; i++) begin
            bit blocked = 1'b0;
            for (int j = 0; j < i; j++)
                if (g[j] && ref_bank(a[j]) == ref_bank(a[i]) && a[j] != a[i]) blocked = 1'b1;
            if (p[i] && !blocked) g[i] = 1'b1;
        end
        return g;
    endfunction

    task automatic run_op(input logic [NL-1:0] mask, input logic [31:0] a [NL],
                          input int miss_pct, input bit noise, input string tag);
        logic [NL-1:0] pend = mask;
        logic [NL-1:0] seen = '0;
        logic [NL-1:0] eg;
        bit ed;
        bit miss;
        int cyc = 0;
        @(negedge clk);
        op_valid = 1'b1;
        op_mask  = mask;
        for (int i = 0; i < NL; i++) op_addr[i*AW +: AW] = a[i];
        cache_miss = 1'b0;
        #1;
        check(!busy && grant == '0 && !done, {"R8/R9 idle before accept ", tag},
              {busy, grant, done}, 0);
        do begin
            @(negedge clk);
            miss = (($urandom % 100) < miss_pct);
            eg = miss ? '0 : ref_pick(pend, a);
            ed = ((pend & ~eg) == '0);
            cache_miss = miss;
            if (noise && !ed) begin
                op_valid = 1'b1;
                op_mask  = NL'($urandom);
                op_addr  = {$urandom, $urandom, $urandom, $urandom};
            end else begin
                op_valid = 1'b0;
            end
            #1;
            check(busy == 1'b1, {"R6 busy during op ", tag}, busy, 1);
            check(grant == eg, {"R2/R3/R4/R7 grant ", tag}, grant, eg);
            check(done == ed, {"R8 done ", tag}, done, ed);
            check((grant & ~mask) == '0, {"R5 inactive lane ", tag}, grant, mask);
            for (int i = 0; i < NL; i++)
                check(lane_bank[i*4 +: 4] == ref_bank(a[i]), {"R1 bank ", tag},
                      lane_bank[i*4 +: 4], ref_bank(a[i]));
            check((seen & grant) == '0, {"R8 lane granted twice ", tag}, grant, seen);
            seen |= grant;
            pend &= ~eg;
            cyc++;
        end while (!ed && cyc < 200);
        check(seen == mask, {"R8 all lanes served ", tag}, seen, mask);
        op_valid   = 1'b0;
        cache_miss = 1'b0;
    endtask

    logic [31:0] av [NL];

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_mask = '0; op_addr = '0; cache_miss = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && grant == '0 && !done, "R9 reset state", {busy, grant, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && grant == '0 && !done, "R9 after reset", {busy, grant, done}, 0);

        // R2: four distinct banks in one cycle
        for (int i = 0; i < NL; i++) av[i] = 32'(i) << 12;
        run_op(4'hF, av, 0, 0, "R2 distinct banks");
        // R4: same bank, different words -> four cycles ascending
        for (int i = 0; i < NL; i++) av[i] = 32'(i) << 2;
        run_op(4'hF, av, 0, 0, "R4 serial chain");
        // R3: identical addresses share one access
        for (int i = 0; i < NL; i++) av[i] = 32'h1234_5678;
        run_op(4'hF, av, 0, 0, "R3 identical");
        // R1: aliasing between hashed fields
        av[0] = 32'h0000_1000; av[1] = 32'h0100_0000; av[2] = 32'h0100_1000; av[3] = 32'h0000_0000;
        run_op(4'hF, av, 0, 0, "R1 hash alias");
        // R3+R4: shared address mixed with a conflict
        av[0] = 32'h0000_5010; av[1] = 32'h0000_5020; av[2] = 32'h0000_5010; av[3] = 32'h0000_6000;
        run_op(4'hF, av, 0, 0, "R3 mixed group");
        // R5: zero mask and sparse mask
        run_op(4'h0, av, 0, 0, "R5 zero mask");
        av[1] = 32'h0000_3004; av[3] = 32'h0000_3008;
        run_op(4'hA, av, 0, 0, "R5 sparse mask");
        // R7: misses during a conflict chain, R6 noise while busy
        for (int i = 0; i < NL; i++) av[i] = 32'h0000_7000 + (32'(i) << 2);
        run_op(4'hF, av, 50, 1, "R7 miss chain");
        run_op(4'h0, av, 100, 0, "R7 miss zero mask");

        // Random phase, narrow address pool for frequent conflicts
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < NL; i++)
                av[i] = (32'($urandom % 4) << 12) | (32'($urandom % 2) << 24) | (32'($urandom % 2) << 2);
            run_op(NL'($urandom), av, (k % 3) * 20, k[0], "random");
        end

        @(negedge clk);
        #1;
        check(!busy && !done, "R8 idle at end", {busy, done}, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule